// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This unit performs the four partial-word transfers that let software move a 32-bit value that straddles a word boundary: two load variants that fold bytes of a memory word into an existing register value, and two store variants that fold bytes of a register value into an existing memory word. A caller hands over the byte address, a two-bit operation code, the current register contents and a flag telling whether the destination register is the hard-wired zero register. The unit then talks to a word-aligned memory port on its own.

Every operation touches only the aligned word that contains the byte address. The two low address bits select how many bytes move and in which direction. Loads finish after one read and return a merged register value with a write-enable. Stores read the aligned word, merge the register bytes into it and write the result back to the same address. A one-cycle completion pulse marks the end of each operation. The unit takes no new request until that pulse has gone by.

Top module: `uwm_unit`

## Requirements
- R1: Every memory request carries the aligned address: the byte address with its two low bits forced to zero.
- R2: Operation code 2'b00 (load, left variant) with offset k returns the register value whose byte lanes 3-k..3 hold memory bytes 0..k and whose lanes below 3-k keep the old register bytes.
- R3: Operation code 2'b01 (load, right variant) with offset k returns memory bytes k..3 in lanes 0..3-k, and the old register bytes in the lanes above 3-k.
- R4: Operation code 2'b10 (store, left variant) with offset k writes back a word whose lanes 0..k hold register bytes 3-k..3, and whose lanes above k keep the memory bytes that were read.
- R5: Operation code 2'b11 (store, right variant) with offset k writes back a word whose lanes k..3 hold register bytes 0..3-k, and whose lanes below k keep the memory bytes that were read.
- R6: A load issues exactly one read and no write. A store issues exactly one read and then exactly one write, and the write goes to the address that was read.
- R7: A load whose destination-is-zero flag is set still performs its read, but result_we_o stays low at completion.
- R8: A start request is ignored while the unit is busy, including the cycle of the completion pulse. No memory request is made while the unit is idle.
- R9: done_o is high for exactly one cycle per operation. result_we_o is only ever high together with done_o, and only for loads.
- R10: After reset, busy_o, done_o, mem_req_o and result_we_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new operation (taken only when idle) |
| op_i | input | 2 | Operation code: bit 1 selects store, bit 0 selects the right variant |
| addr_i | input | AW | Byte address of the access |
| reg_i | input | DW | Current register value |
| dst_zero_i | input | 1 | Destination is the zero register (loads only) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DW | Merged register value from the last load |
| result_we_o | output | 1 | Register write enable, high with done_o |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Aligned word address |
| mem_wdata_o | output | DW | Merged word to write |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata_i | input | DW | Read data, valid with mem_ack_i |

## Verification
The two events that can meet in one cycle are a fresh start request and the completion pulse of the operation still running. The bench holds start high through a whole load, with a conflicting store code and a different address on the inputs, and keeps it high during the done cycle. It then passes judgement on three points: the monitor must see exactly one read and no write for that load, the result must match the load's own expected value, and the bus and busy_o must stay quiet for several cycles after the pulse.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

  typedef enum logic [1:0] {
    OP_LD_LEFT  = 2'b00,
    OP_LD_RIGHT = 2'b01,
    OP_ST_LEFT  = 2'b10,
    OP_ST_RIGHT = 2'b11
  } uwm_op_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_MERGE = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } uwm_state_t;

  function automatic logic op_is_store(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_right(input logic [1:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/uwm_merge.sv
module uwm_merge #(
  parameter int DW = 32
) (
  input  logic [1:0]                 op,
  input  logic [$clog2(DW/8)-1:0]    off,
  input  logic [DW-1:0]              regv,
  input  logic [DW-1:0]              memv,
  output logic [DW-1:0]              load_word,
  output logic [DW-1:0]              store_word
);
  import uwm_pkg::*;

  localparam int NB = DW / 8;
  localparam int SW = $clog2(DW) + 1;

  logic [SW-1:0] sh_lo;
  logic [SW-1:0] sh_lo1;
  logic [SW-1:0] sh_hi;
  logic [DW-1:0] ones;

  // shift amounts in bits: offset lanes, offset+1 lanes, and the complement
  always_comb begin
    ones   = '1;
    sh_lo  = SW'(off) << 3;
    sh_lo1 = sh_lo + SW'(8);
    sh_hi  = SW'((NB - 1) - int'(off)) << 3;
  end

  // loads: memory bytes enter the register from one end
  always_comb begin
    if (op_is_right(op))
      load_word = (regv & ~(ones >> sh_lo)) | (memv >> sh_lo);
    else
      load_word = (regv & (ones >> sh_lo1)) | (memv << sh_hi);
  end

  // stores: register bytes enter the memory word from one end
  always_comb begin
    if (op_is_right(op))
      store_word = (regv << sh_lo) | (memv & ~(ones << sh_lo));
    else
      store_word = (regv >> sh_hi) | (memv & (ones << sh_lo1));
  end

endmodule

// File: rtl/uwm_ctrl.sv
module uwm_ctrl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  is_store,
  input  logic                  mem_ack,
  output uwm_pkg::uwm_state_t   state,
  output logic                  accept,
  output logic                  rd_done
);
  import uwm_pkg::*;

  uwm_state_t nxt;

  assign accept  = (state == ST_IDLE) && start;
  assign rd_done = (state == ST_READ) && mem_ack;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_READ;
      ST_READ:  if (mem_ack) nxt = is_store ? ST_MERGE : ST_DONE;
      ST_MERGE: nxt = ST_WRITE;
      ST_WRITE: if (mem_ack) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE)); // R9

  AST_WRITE_AFTER_MERGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE) |-> ($past(state) == ST_MERGE || $past(state) == ST_WRITE)); // R6

endmodule

// File: rtl/uwm_unit.sv
module uwm_unit #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] reg_i,
  input  logic          dst_zero_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic          result_we_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  import uwm_pkg::*;

  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);

  uwm_state_t    st;
  logic          accept;
  logic          rd_done;

  logic [1:0]    op_q;
  logic [OW-1:0] off_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] reg_q;
  logic          dst0_q;
  logic [DW-1:0] mem_q;
  logic [DW-1:0] result_q;
  logic          res_we_q;
  logic [DW-1:0] wdata_q;

  logic [DW-1:0] merge_mem;
  logic [DW-1:0] load_word;
  logic [DW-1:0] store_word;

  uwm_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .is_store (op_is_store(op_q)),
    .mem_ack  (mem_ack_i),
    .state    (st),
    .accept   (accept),
    .rd_done  (rd_done)
  );

  // read data feeds the merge directly in the acknowledge cycle
  assign merge_mem = rd_done ? mem_rdata_i : mem_q;

  uwm_merge #(.DW(DW)) u_merge (
    .op         (op_q),
    .off        (off_q),
    .regv       (reg_q),
    .memv       (merge_mem),
    .load_word  (load_word),
    .store_word (store_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= '0;
      off_q    <= '0;
      addr_q   <= '0;
      reg_q    <= '0;
      dst0_q   <= 1'b0;
      mem_q    <= '0;
      result_q <= '0;
      res_we_q <= 1'b0;
      wdata_q  <= '0;
    end else begin
      res_we_q <= 1'b0;
      if (accept) begin
        op_q   <= op_i;
        off_q  <= addr_i[OW-1:0];
        addr_q <= {addr_i[AW-1:OW], {OW{1'b0}}};
        reg_q  <= reg_i;
        dst0_q <= dst_zero_i;
      end
      if (rd_done) begin
        mem_q <= mem_rdata_i;
        if (!op_is_store(op_q)) begin
          result_q <= load_word;
          res_we_q <= !dst0_q;
        end
      end
      if (st == ST_MERGE) wdata_q <= store_word;
    end
  end

  assign busy_o      = (st != ST_IDLE);
  assign done_o      = (st == ST_DONE);
  assign mem_req_o   = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we_o    = (st == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign result_o    = result_q;
  assign result_we_o = res_we_q;

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[OW-1:0] == '0)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R6

  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> op_q[1]); // R6

  AST_ZERO_DEST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done_o && dst0_q) |-> !result_we_o); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o); // R8

  AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    result_we_o |-> (done_o && !op_q[1])); // R9

endmodule

// File: tb/sim_uwm_unit.sv
module sim_uwm_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] addr_i = '0;
  logic [31:0] reg_i = '0;
  logic        dst_zero_i = 1'b0;
  logic        busy_o, done_o, result_we_o, mem_req_o, mem_we_o;
  logic [31:0] result_o, mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #5 clk = ~clk;

  uwm_unit u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
    .reg_i(reg_i), .dst_zero_i(dst_zero_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .result_we_o(result_we_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  int total = 0;
  int bad = 0;
  int n_rd = 0;
  int n_wr = 0;
  int lat = 0;
  int wait_cnt = 0;
  logic [7:0] mem_b [0:63];

  typedef struct packed {
    logic [1:0]  op;
    logic        dz;
    logic [5:0]  a;
    logic [31:0] val;
  } sb_t;
  sb_t sbq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [5:0] a);
    return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
  endfunction

  // byte-lane model written from the requirement text
  function automatic logic [31:0] model(input logic [1:0] op, input int k,
                                        input logic [31:0] r, input logic [31:0] m);
    logic [31:0] res;
    for (int j = 0; j < 4; j++) begin
      case (op)
        2'b00: res[8*j +: 8] = (j >= 3-k) ? m[8*(j-(3-k)) +: 8] : r[8*j +: 8]; // R2
        2'b01: res[8*j +: 8] = (j <= 3-k) ? m[8*(j+k) +: 8]     : r[8*j +: 8]; // R3
        2'b10: res[8*j +: 8] = (j <= k)   ? r[8*(j+3-k) +: 8]   : m[8*j +: 8]; // R4
        default: res[8*j +: 8] = (j >= k) ? r[8*(j-k) +: 8]     : m[8*j +: 8]; // R5
      endcase
    end
    return res;
  endfunction

  // memory responder: acknowledge after lat idle cycles
  always @(negedge clk) begin
    if (rst) begin
      mem_ack_i = 1'b0;
      wait_cnt = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        logic [5:0] a;
        wait_cnt = 0;
        a = mem_addr_o[5:0];
        chk(mem_addr_o[1:0] == 2'b00, "R1 aligned address", mem_addr_o, {mem_addr_o[31:2], 2'b00});
        if (mem_we_o) begin
          chk(n_rd == 1, "R6 read precedes write", n_rd, 1);
          for (int j = 0; j < 4; j++) mem_b[a+j] = mem_wdata_o[8*j +: 8];
          n_wr++;
        end else begin
          mem_rdata_i = word_at(a);
          n_rd++;
        end
        mem_ack_i = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  // scoreboard monitor
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o && prev_done) chk(1'b0, "R9 done longer than one cycle", 1, 0);
      if (result_we_o && !done_o) chk(1'b0, "R9 write enable without done", 1, 0);
      if (done_o) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          sb_t it;
          it = sbq.pop_front();
          chk(n_rd == 1, "R6 read count", n_rd, 1);
          chk(n_wr == (it.op[1] ? 1 : 0), "R6 write count", n_wr, it.op[1] ? 1 : 0);
          if (it.op[1]) begin
            chk(word_at(it.a) == it.val, it.op[0] ? "R5 store right word" : "R4 store left word",
                word_at(it.a), it.val);
            chk(!result_we_o, "R9 no register write on store", result_we_o, 0);
          end else if (it.dz) begin
            chk(!result_we_o, "R7 zero destination not written", result_we_o, 0);
          end else begin
            chk(result_we_o, "R9 load write enable", result_we_o, 1);
            chk(result_o == it.val, it.op[0] ? "R3 load right value" : "R2 load left value",
                result_o, it.val);
          end
        end
      end
      prev_done = done_o;
    end
  end

  task automatic push_exp(input logic [1:0] op, input logic [31:0] addr,
                          input logic [31:0] rv, input logic dz);
    sb_t it;
    it.op  = op;
    it.dz  = dz;
    it.a   = {addr[5:2], 2'b00};
    it.val = model(op, int'(addr[1:0]), rv, word_at(it.a));
    sbq.push_back(it);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] rv, input logic dz, input int l);
    @(negedge clk);
    push_exp(op, addr, rv, dz);
    n_rd = 0; n_wr = 0; lat = l;
    start_i = 1'b1; op_i = op; addr_i = addr; reg_i = rv; dst_zero_i = dz;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  // start held across a whole load, including its done cycle (R8)
  task automatic busy_start(input logic [31:0] addr, input logic [31:0] rv);
    @(negedge clk);
    push_exp(2'b00, addr, rv, 1'b0);
    n_rd = 0; n_wr = 0; lat = 1;
    start_i = 1'b1; op_i = 2'b00; addr_i = addr; reg_i = rv; dst_zero_i = 1'b0;
    @(negedge clk);
    op_i = 2'b11; addr_i = addr + 32'd8; reg_i = ~rv;
    while (!done_o) @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!busy_o && !mem_req_o, "R8 start during busy ignored", {busy_o, mem_req_o}, 0);
    end
    chk(n_rd == 1 && n_wr == 0, "R8 single access for held start", n_rd + n_wr, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_b[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !result_we_o, "R10 reset state",
        {busy_o, done_o, mem_req_o, result_we_o}, 0);
    rst = 1'b0;
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] ad;
        ad = 32'h0000_4000 | 32'((op * 4 + k) * 4 + k);
        do_op(2'(op), ad, 32'hA1B2_C3D4 ^ 32'(op * 32'h0101_0101 + k * 32'h1357_9BDF), 1'b0, (op + k) % 3);
      end
    end
    do_op(2'b00, 32'h0000_4006, 32'h5566_7788, 1'b1, 2); // R7
    do_op(2'b01, 32'h0000_4011, 32'h99AA_BBCC, 1'b1, 0); // R7
    do_op(2'b11, 32'h0000_4022, 32'h0F1E_2D3C, 1'b0, 0); // R5 then read back
    do_op(2'b01, 32'h0000_4020, 32'hFFFF_FFFF, 1'b0, 1); // R3
    busy_start(32'h0000_4031, 32'h1234_5678);           // R8
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule